// File: doc/BRIEF.md
# Game State Swap Sequencer

This controller replaces the game running on a soft console with another one. A host raises a one-cycle request together with a target slot number. The sequencer first lets the video frame currently being drawn run to completion. It then asks the CPU to halt and waits for the CPU's acknowledge. With the CPU stopped, it saves the outgoing game to its slot in persistent storage. The saved data is the whole working-memory image followed by the CPU register snapshot. It then zeroes all live state, both memory and registers. Last, it fills memory and registers from the incoming game's slot. It releases the CPU only after the final word of that load has been written.

Storage is divided into equal slots. A slot's base address is its index multiplied by a power-of-two stride. Every copy moves one word per cycle and waits for the ready signal of the port being written. The CPU snapshot port never stalls. The controller is built as an explicit state machine with these states: `ST_IDLE`, `ST_WAIT_FRAME`, `ST_HALT`, `ST_SAVE`, `ST_CLEAR`, `ST_LOAD` and `ST_FINISH`. Its transitions are:
- ST_IDLE to ST_WAIT_FRAME on a request.
- ST_WAIT_FRAME to ST_HALT on frame done.
- ST_HALT to ST_SAVE on the halt acknowledge.
- ST_SAVE to ST_CLEAR, ST_CLEAR to ST_LOAD and ST_LOAD to ST_FINISH, each when the last word of that phase is accepted.
- ST_FINISH back to ST_IDLE unconditionally.

Top module: `game_swap_seq`

## Requirements
- R1: `busy` is 0 in idle. It goes high in the cycle after an accepted request and stays high through the cycle in which `done` is high.
- R2: `cpu_halt_req` stays low until `frame_done` has been sampled high while the sequencer waits for the frame. A `frame_done` in the request cycle itself does not count. `cpu_halt_req` rises in the cycle after that sample.
- R3: No write to storage, memory or the snapshot port happens before `cpu_halt_ack` has been sampled high. `cpu_halt_req` stays high from that point until the last load word has been written.
- R4: The save phase writes storage at offsets 0 to MW-1 with memory words 0 to MW-1. It then writes offsets MW to MW+SNAP_WORDS-1 with snapshot registers 0 to SNAP_WORDS-1. MW is 2^MEM_AW.
- R5: The storage address is base + offset, where base is slot × 2^ceil(log2(MW+SNAP_WORDS)). The save phase uses the current slot and the load phase uses the requested slot.
- R6: After the save and before the load, every memory word and every snapshot register is written with zero, in ascending order with memory first.
- R7: The load phase copies storage offsets 0 to MW-1 into memory words 0 to MW-1. It then copies offsets MW onward into snapshot registers 0 onward.
- R8: Each transfer moves one word. A memory or storage write completes only in a cycle where `mem_rdy` or `st_rdy` is high, and the address is held while ready is low. Snapshot writes complete every cycle.
- R9: In the cycle after the last load write, `done` is high for exactly one cycle and `cpu_halt_req` is low. In the following cycle `busy` is low, and the requested slot has become the current slot.
- R10: A request that arrives while `busy` is high has no effect on the slot being loaded and does not start a second swap.
- R11: After reset the sequencer is idle with `busy`, `done`, `cpu_halt_req` and all write enables low, and the current slot is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_req | input | 1 | Swap request, one cycle |
| sw_slot | input | SLOT_W | Slot of the game to switch to |
| frame_done | input | 1 | Current frame has finished drawing |
| cpu_halt_req | output | 1 | Halt request to the CPU |
| cpu_halt_ack | input | 1 | CPU reports it has stopped |
| snap_idx | output | SNAP_AW | CPU register snapshot index (read and write) |
| snap_rdata | input | DW | Snapshot register read data |
| snap_we | output | 1 | Snapshot register write strobe |
| snap_wdata | output | DW | Snapshot register write data |
| mem_addr | output | MEM_AW | Working memory address (read and write) |
| mem_we | output | 1 | Working memory write request |
| mem_wdata | output | DW | Working memory write data |
| mem_rdata | input | DW | Working memory read data |
| mem_rdy | input | 1 | Working memory accepts a write |
| st_addr | output | ST_AW | Storage address |
| st_we | output | 1 | Storage write request |
| st_wdata | output | DW | Storage write data |
| st_rdata | input | DW | Storage read data |
| st_rdy | input | 1 | Storage accepts a write |
| busy | output | 1 | Swap in progress |
| done | output | 1 | Swap finished, one cycle |

## Verification
The bench builds the block with DW=8, MEM_AW=4, SNAP_WORDS=4 and SLOTS=4. This gives a 16-word image, a 4-register snapshot and a 32-word slot stride, so a complete swap takes only a few dozen cycles. With these values the snapshot sits at offsets 16 to 19, away from the image. Slot 3 at base 96 drives the top storage address bits, and four swaps cover a reload of the same slot, a return to slot 0, and stalls on both memory and storage ready.

// File: rtl/gss_pkg.sv
`timescale 1ns/1ps
package gss_pkg;
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_WAIT_FRAME = 3'd1,
        ST_HALT       = 3'd2,
        ST_SAVE       = 3'd3,
        ST_CLEAR      = 3'd4,
        ST_LOAD       = 3'd5,
        ST_FINISH     = 3'd6
    } gss_state_e;
endpackage

// File: rtl/gss_offset_ctr.sv
`timescale 1ns/1ps
module gss_offset_ctr #(
    parameter int TOTAL = 20,
    parameter int OFF_W = $clog2(TOTAL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [OFF_W-1:0] off,
    output logic             last
);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(TOTAL - 1);

    assign last = (off == LAST_OFF);

    // Wraps to zero after the final word so every phase starts at offset 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off <= '0;
        end else if (step) begin
            off <= last ? '0 : off + 1'b1;
        end
    end

    a_r8_offset_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        off <= LAST_OFF);
endmodule

// File: rtl/gss_slot_map.sv
`timescale 1ns/1ps
module gss_slot_map #(
    parameter int SLOT_W     = 2,
    parameter int STRIDE_LOG = 5,
    parameter int PORTS      = 2,
    localparam int ST_AW     = SLOT_W + STRIDE_LOG
) (
    input  logic [PORTS-1:0][SLOT_W-1:0] slot,
    output logic [PORTS-1:0][ST_AW-1:0]  base
);
    // Power-of-two stride: the base is the slot index shifted up, no adder needed.
    for (genvar g = 0; g < PORTS; g++) begin : g_port
        assign base[g] = {slot[g], {STRIDE_LOG{1'b0}}};
    end
endmodule

// File: rtl/gss_fsm.sv
`timescale 1ns/1ps
module gss_fsm
    import gss_pkg::*;
#(
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_req,
    input  logic [SLOT_W-1:0] sw_slot,
    input  logic              frame_done,
    input  logic              halt_ack,
    input  logic              step,
    input  logic              last,
    output gss_state_e        state,
    output logic [SLOT_W-1:0] cur_slot,
    output logic [SLOT_W-1:0] new_slot,
    output logic              busy,
    output logic              halt_req,
    output logic              done
);
    gss_state_e nxt;
    logic       phase_end;

    assign phase_end = step && last;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:       if (sw_req)     nxt = ST_WAIT_FRAME;
            ST_WAIT_FRAME: if (frame_done) nxt = ST_HALT;
            ST_HALT:       if (halt_ack)   nxt = ST_SAVE;
            ST_SAVE:       if (phase_end)  nxt = ST_CLEAR;
            ST_CLEAR:      if (phase_end)  nxt = ST_LOAD;
            ST_LOAD:       if (phase_end)  nxt = ST_FINISH;
            ST_FINISH:                     nxt = ST_IDLE;
            default:                       nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_slot <= '0;
            new_slot <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && sw_req) begin
                new_slot <= sw_slot;
            end
            if (state == ST_LOAD && phase_end) begin
                cur_slot <= new_slot;
            end
        end
    end

    always_comb begin
        busy     = 1'b1;
        halt_req = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_IDLE:       busy = 1'b0;
            ST_WAIT_FRAME: ;
            ST_HALT,
            ST_SAVE,
            ST_CLEAR,
            ST_LOAD:       halt_req = 1'b1;
            ST_FINISH:     done = 1'b1;
            default:       busy = 1'b0;
        endcase
    end

    a_r2_halt_follows_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_req) |-> $past(frame_done));
    a_r1_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    a_r10_target_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(new_slot));
endmodule

// File: rtl/gss_xfer_path.sv
`timescale 1ns/1ps
module gss_xfer_path
    import gss_pkg::*;
#(
    parameter int DW      = 8,
    parameter int MEM_AW  = 16,
    parameter int SNAP_AW = 3,
    parameter int OFF_W   = 17,
    parameter int ST_AW   = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  gss_state_e         state,
    input  logic [OFF_W-1:0]   off,
    input  logic [ST_AW-1:0]   base_cur,
    input  logic [ST_AW-1:0]   base_new,
    input  logic [DW-1:0]      mem_rdata,
    input  logic [DW-1:0]      snap_rdata,
    input  logic [DW-1:0]      st_rdata,
    input  logic               mem_rdy,
    input  logic               st_rdy,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic               mem_we,
    output logic [DW-1:0]      mem_wdata,
    output logic [SNAP_AW-1:0] snap_idx,
    output logic               snap_we,
    output logic [DW-1:0]      snap_wdata,
    output logic [ST_AW-1:0]   st_addr,
    output logic               st_we,
    output logic [DW-1:0]      st_wdata,
    output logic               step
);
    localparam int               MW     = 1 << MEM_AW;
    localparam logic [OFF_W-1:0] IMG_END = OFF_W'(MW);

    logic             in_img;
    logic [OFF_W-1:0] snap_off;

    assign in_img   = (off < IMG_END);
    assign snap_off = off - IMG_END;
    assign mem_addr = MEM_AW'(off);
    assign snap_idx = snap_off[SNAP_AW-1:0];

    always_comb begin
        mem_we     = 1'b0;
        mem_wdata  = '0;
        snap_we    = 1'b0;
        snap_wdata = '0;
        st_we      = 1'b0;
        st_wdata   = '0;
        st_addr    = '0;
        step       = 1'b0;
        unique case (state)
            ST_SAVE: begin
                st_we    = 1'b1;
                st_addr  = base_cur + ST_AW'(off);
                st_wdata = in_img ? mem_rdata : snap_rdata;
                step     = st_rdy;
            end
            ST_CLEAR: begin
                if (in_img) begin
                    mem_we = 1'b1;
                    step   = mem_rdy;
                end else begin
                    snap_we = 1'b1;
                    step    = 1'b1;
                end
            end
            ST_LOAD: begin
                st_addr = base_new + ST_AW'(off);
                if (in_img) begin
                    mem_we    = 1'b1;
                    mem_wdata = st_rdata;
                    step      = mem_rdy;
                end else begin
                    snap_we    = 1'b1;
                    snap_wdata = st_rdata;
                    step       = 1'b1;
                end
            end
            default: ;
        endcase
    end

    a_r8_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_rdy) |=> (mem_we && $stable(mem_addr)));
    a_r8_st_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && !st_rdy) |=> (st_we && $stable(st_addr)));
endmodule

// File: rtl/game_swap_seq.sv
`timescale 1ns/1ps
module game_swap_seq
    import gss_pkg::*;
#(
    parameter int  DW         = 8,
    parameter int  MEM_AW     = 16,
    parameter int  SNAP_WORDS = 8,
    parameter int  SLOTS      = 4,
    localparam int MW         = 1 << MEM_AW,
    localparam int TOTAL      = MW + SNAP_WORDS,
    localparam int OFF_W      = $clog2(TOTAL),
    localparam int SLOT_W     = $clog2(SLOTS),
    localparam int SNAP_AW    = $clog2(SNAP_WORDS),
    localparam int ST_AW      = SLOT_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_req,
    input  logic [SLOT_W-1:0]  sw_slot,
    input  logic               frame_done,
    output logic               cpu_halt_req,
    input  logic               cpu_halt_ack,
    output logic [SNAP_AW-1:0] snap_idx,
    input  logic [DW-1:0]      snap_rdata,
    output logic               snap_we,
    output logic [DW-1:0]      snap_wdata,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic               mem_we,
    output logic [DW-1:0]      mem_wdata,
    input  logic [DW-1:0]      mem_rdata,
    input  logic               mem_rdy,
    output logic [ST_AW-1:0]   st_addr,
    output logic               st_we,
    output logic [DW-1:0]      st_wdata,
    input  logic [DW-1:0]      st_rdata,
    input  logic               st_rdy,
    output logic               busy,
    output logic               done
);
    gss_state_e                    state;
    logic [OFF_W-1:0]              off;
    logic                          last;
    logic                          step;
    logic [SLOT_W-1:0]             cur_slot;
    logic [SLOT_W-1:0]             new_slot;
    logic [1:0][SLOT_W-1:0]        slot_pair;
    logic [1:0][ST_AW-1:0]         base_pair;

    assign slot_pair[0] = cur_slot;
    assign slot_pair[1] = new_slot;

    gss_fsm #(.SLOT_W(SLOT_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_req     (sw_req),
        .sw_slot    (sw_slot),
        .frame_done (frame_done),
        .halt_ack   (cpu_halt_ack),
        .step       (step),
        .last       (last),
        .state      (state),
        .cur_slot   (cur_slot),
        .new_slot   (new_slot),
        .busy       (busy),
        .halt_req   (cpu_halt_req),
        .done       (done)
    );

    gss_offset_ctr #(.TOTAL(TOTAL), .OFF_W(OFF_W)) ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .off   (off),
        .last  (last)
    );

    gss_slot_map #(.SLOT_W(SLOT_W), .STRIDE_LOG(OFF_W), .PORTS(2)) map_i (
        .slot (slot_pair),
        .base (base_pair)
    );

    gss_xfer_path #(
        .DW(DW), .MEM_AW(MEM_AW), .SNAP_AW(SNAP_AW), .OFF_W(OFF_W), .ST_AW(ST_AW)
    ) path_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .off        (off),
        .base_cur   (base_pair[0]),
        .base_new   (base_pair[1]),
        .mem_rdata  (mem_rdata),
        .snap_rdata (snap_rdata),
        .st_rdata   (st_rdata),
        .mem_rdy    (mem_rdy),
        .st_rdy     (st_rdy),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .snap_idx   (snap_idx),
        .snap_we    (snap_we),
        .snap_wdata (snap_wdata),
        .st_addr    (st_addr),
        .st_we      (st_we),
        .st_wdata   (st_wdata),
        .step       (step)
    );

    a_r3_ack_before_copy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_we) |-> $past(cpu_halt_ack));
    a_r3_halted_during_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || st_we || snap_we) |-> cpu_halt_req);
    a_r9_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cpu_halt_req && $past(cpu_halt_req)));
endmodule

// File: tb/game_swap_seq_tb_top.sv
`timescale 1ns/1ps
module game_swap_seq_tb_top;
    localparam int MW   = 16;
    localparam int SW   = 4;
    localparam int STR  = 32;
    localparam int STN  = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_req = 1'b0;
    logic [1:0] sw_slot = '0;
    logic       frame_done = 1'b0;
    logic       cpu_halt_req;
    logic       cpu_halt_ack = 1'b0;
    logic [1:0] snap_idx;
    logic [7:0] snap_rdata;
    logic       snap_we;
    logic [7:0] snap_wdata;
    logic [3:0] mem_addr;
    logic       mem_we;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata;
    logic       mem_rdy = 1'b1;
    logic [6:0] st_addr;
    logic       st_we;
    logic [7:0] st_wdata;
    logic [7:0] st_rdata;
    logic       st_rdy = 1'b1;
    logic       busy;
    logic       done;

    logic [7:0] mem_m  [MW];
    logic [7:0] snap_m [SW];
    logic [7:0] st_m   [STN];

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit wd_fired = 0;
    int rdy_mode = 0;
    int ack_lat = 1;
    int ack_cnt = 0;
    logic [15:0] lfsr = 16'hACE1;

    // reference model state
    int m_ph = 0;
    int m_off = 0;
    int m_cur = 0;
    int m_new = 0;

    always #10 clk = ~clk;

    game_swap_seq #(.DW(8), .MEM_AW(4), .SNAP_WORDS(SW), .SLOTS(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_slot(sw_slot),
        .frame_done(frame_done), .cpu_halt_req(cpu_halt_req), .cpu_halt_ack(cpu_halt_ack),
        .snap_idx(snap_idx), .snap_rdata(snap_rdata), .snap_we(snap_we), .snap_wdata(snap_wdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rdy(mem_rdy), .st_addr(st_addr), .st_we(st_we), .st_wdata(st_wdata),
        .st_rdata(st_rdata), .st_rdy(st_rdy), .busy(busy), .done(done)
    );

    assign mem_rdata  = mem_m[mem_addr];
    assign snap_rdata = snap_m[snap_idx];
    assign st_rdata   = st_m[st_addr];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    // environment: memories written at the clock edge
    always @(posedge clk) begin
        if (mem_we && mem_rdy) mem_m[mem_addr] <= mem_wdata;
        if (snap_we) snap_m[snap_idx] <= snap_wdata;
        if (st_we && st_rdy) st_m[st_addr] <= st_wdata;
    end

    // behavioural reference: phase 0 idle, 1 frame wait, 2 halt, 3 save, 4 clear, 5 load, 6 finish
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_off = 0; m_cur = 0; m_new = 0;
        end else begin
            case (m_ph)
                0: if (sw_req) begin m_new = sw_slot; m_ph = 1; end
                1: if (frame_done) m_ph = 2;
                2: if (cpu_halt_ack) begin m_ph = 3; m_off = 0; end
                3: if (st_rdy) begin
                       if (m_off == MW + SW - 1) begin m_off = 0; m_ph = 4; end
                       else m_off++;
                   end
                4, 5: if (m_off >= MW || mem_rdy) begin
                       if (m_off == MW + SW - 1) begin
                           m_off = 0;
                           if (m_ph == 5) begin m_cur = m_new; m_ph = 6; end
                           else m_ph = 5;
                       end else m_off++;
                   end
                default: m_ph = 0;
            endcase
        end
    end

    // per-cycle comparison, then drive ready and acknowledge
    always @(negedge clk) begin
        cyc++;
        if (cyc > 20000 && !wd_fired) begin
            wd_fired = 1;
            chk(0, "R9 watchdog", cyc, 20000);
            summary();
            $finish;
        end
        if (rst_n) begin
            chk(busy == (m_ph != 0), "R1 busy", busy, m_ph != 0);
            chk(cpu_halt_req == (m_ph >= 2 && m_ph <= 5), "R3 halt_req", cpu_halt_req, m_ph >= 2 && m_ph <= 5);
            chk(done == (m_ph == 6), "R9 done", done, m_ph == 6);
            chk(st_we == (m_ph == 3), "R4 st_we", st_we, m_ph == 3);
            chk(mem_we == ((m_ph == 4 || m_ph == 5) && m_off < MW), "R6/R7 mem_we", mem_we, 0);
            chk(snap_we == ((m_ph == 4 || m_ph == 5) && m_off >= MW), "R6/R7 snap_we", snap_we, 0);
            if (m_ph == 3) begin
                chk(st_addr == m_cur * STR + m_off, "R5 save addr", st_addr, m_cur * STR + m_off);
                if (m_off < MW)
                    chk(st_wdata == mem_m[m_off], "R4 image word", st_wdata, mem_m[m_off]);
                else
                    chk(st_wdata == snap_m[m_off - MW], "R4 snapshot word", st_wdata, snap_m[m_off - MW]);
            end
            if ((m_ph == 4 || m_ph == 5) && m_off < MW)
                chk(mem_addr == m_off, "R8 mem addr", mem_addr, m_off);
            if ((m_ph == 4 || m_ph == 5) && m_off >= MW)
                chk(snap_idx == m_off - MW, "R8 snap idx", snap_idx, m_off - MW);
            if (m_ph == 4)
                chk((mem_we ? mem_wdata : 8'd0) == 0 && (snap_we ? snap_wdata : 8'd0) == 0,
                    "R6 clear data", mem_we ? mem_wdata : snap_wdata, 0);
            if (m_ph == 5) begin
                chk(st_addr == m_new * STR + m_off, "R5 load addr", st_addr, m_new * STR + m_off);
                if (m_off < MW)
                    chk(mem_wdata == st_m[m_new * STR + m_off], "R7 image word", mem_wdata, st_m[m_new * STR + m_off]);
                else
                    chk(snap_wdata == st_m[m_new * STR + m_off], "R7 snapshot word", snap_wdata, st_m[m_new * STR + m_off]);
            end
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0: begin mem_rdy = 1'b1; st_rdy = 1'b1; end
            1: begin mem_rdy = lfsr[0] | lfsr[3]; st_rdy = lfsr[5] | lfsr[1]; end
            default: begin mem_rdy = lfsr[7] | lfsr[9]; st_rdy = lfsr[2] & lfsr[4]; end
        endcase
        if (cpu_halt_req) begin
            cpu_halt_ack = (ack_cnt >= ack_lat);
            ack_cnt++;
        end else begin
            cpu_halt_ack = 1'b0;
            ack_cnt = 0;
        end
    end

    int b_cur = 0;

    task automatic do_swap(input int n, input int fdelay, input int mode, input int alat,
                           input bit extra, input int xslot);
        logic [7:0] exp_st [STN];
        logic [7:0] pre_mem [MW];
        logic [7:0] pre_snap [SW];
        rdy_mode = mode;
        ack_lat  = alat;
        for (int i = 0; i < STN; i++) exp_st[i] = st_m[i];
        for (int i = 0; i < MW; i++) pre_mem[i] = mem_m[i];
        for (int i = 0; i < SW; i++) pre_snap[i] = snap_m[i];
        for (int i = 0; i < MW; i++) exp_st[b_cur * STR + i] = pre_mem[i];
        for (int i = 0; i < SW; i++) exp_st[b_cur * STR + MW + i] = pre_snap[i];

        sw_req = 1'b1; sw_slot = 2'(n);
        @(negedge clk);
        sw_req = 1'b0;
        if (extra) begin
            sw_req = 1'b1; sw_slot = 2'(xslot);
            chk(busy == 1'b1, "R10 busy at second request", busy, 1);
            @(negedge clk);
            sw_req = 1'b0;
        end
        for (int i = 0; i < fdelay; i++) begin
            chk(cpu_halt_req == 1'b0, "R2 no halt before frame end", cpu_halt_req, 0);
            @(negedge clk);
        end
        chk(cpu_halt_req == 1'b0, "R2 no halt before frame end", cpu_halt_req, 0);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        chk(cpu_halt_req == 1'b1, "R2 halt after frame end", cpu_halt_req, 1);
        if (extra) begin
            repeat (6) @(negedge clk);
            sw_req = 1'b1; sw_slot = 2'(xslot);
            @(negedge clk);
            sw_req = 1'b0;
        end
        while (!done && !wd_fired) @(negedge clk);
        chk(cpu_halt_req == 1'b0, "R9 released with done", cpu_halt_req, 0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", done, 0);
        chk(busy == 1'b0, "R9 idle after done", busy, 0);
        for (int i = 0; i < STN; i++)
            chk(st_m[i] == exp_st[i], "R4/R5 storage contents", st_m[i], exp_st[i]);
        for (int i = 0; i < MW; i++)
            chk(mem_m[i] == exp_st[n * STR + i], "R7 memory loaded", mem_m[i], exp_st[n * STR + i]);
        for (int i = 0; i < SW; i++)
            chk(snap_m[i] == exp_st[n * STR + MW + i], "R7 snapshot loaded", snap_m[i], exp_st[n * STR + MW + i]);
        b_cur = n;
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R10 no second swap", busy, 0);
    endtask

    task automatic mutate(input int k);
        for (int i = 0; i < MW; i++) mem_m[i] = mem_m[i] + 8'(17 * k + i);
        for (int i = 0; i < SW; i++) snap_m[i] = snap_m[i] ^ 8'(k * 5 + 1);
    endtask

    initial begin
        for (int i = 0; i < MW; i++) mem_m[i] = 8'(i * 13 + 1);
        for (int i = 0; i < SW; i++) snap_m[i] = 8'(8'hA0 + i);
        for (int i = 0; i < STN; i++) st_m[i] = 8'(i * 7 + 3);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R11 busy after reset", busy, 0);
        chk(done == 1'b0, "R11 done after reset", done, 0);
        chk(cpu_halt_req == 1'b0, "R11 halt after reset", cpu_halt_req, 0);
        chk((mem_we | st_we | snap_we) == 1'b0, "R11 no writes after reset", mem_we | st_we | snap_we, 0);
        // first swap saves to slot 0, which proves the reset current slot
        do_swap(2, 6, 0, 1, 0, 0);
        mutate(1);
        do_swap(3, 0, 1, 3, 1, 1);
        mutate(2);
        do_swap(3, 2, 2, 0, 0, 0);
        mutate(3);
        do_swap(0, 3, 1, 2, 0, 0);
        summary();
        $finish;
    end
endmodule